// File: doc/BRIEF.md
# Page Load Write Controller

This block is the write front end of a byte-wide parallel nonvolatile memory, modelled with a single clock. It samples three active-low controls (chip select, write strobe and read enable), a 15-bit address and an 8-bit data bus. Qualified write strobes fill a one-page load buffer. The upper address bits name the page and the lower seven bits name the byte within it. Every accepted strobe restarts a byte-load timeout. While strobes keep arriving inside that window, the load stays open for as long as the host needs.

When the window runs out with no new strobe, the controller enters a self-timed programming phase of fixed length. It raises `busy` for that whole phase and walks the page buffer in ascending offset order. For each offset that was loaded, it issues one write on the array port. Offsets that were never loaded are skipped. The array is an external register file that accepts one byte per clock through that port.

A byte aimed at a different page from the open load is discarded and latches a sticky error flag. Strobes that arrive while programming runs have no effect.

Top module: `page_load_writer`

## Requirements
- R1: A write strobe is recognised only while `ceN` is 0, `weN` is 0 and `oeN` is 1. Holding `oeN` low, `weN` high or `ceN` high blocks any write, so no load opens and the array is not touched.
- R2: The address of a byte is taken in the first cycle in which all three strobe conditions hold, that is when the later of `ceN` and `weN` falls.
- R3: The data of a byte is the `dataIn` value in the last cycle in which the strobe condition held, that is before the earlier of `ceN` and `weN` rises.
- R4: Address bits 14..7 are the page and bits 6..0 are the byte offset. The first byte of a load fixes the page. A later byte with a different page is dropped: it writes nothing and does not restart the timeout. It also sets `pageErr`, which stays 1 until reset.
- R5: If no new strobe begins, `busy` rises in the cycle exactly LOAD_WINDOW clock edges after the start of the last accepted strobe. A strobe that begins before then extends the load, so the total length of a load is unbounded.
- R6: Programming keeps `busy` high for exactly PROG_CYCLES cycles. During that time the array writes keep the load's page and occur in strictly ascending offset order.
- R7: Only offsets loaded in the current load are written to the array. When an offset is loaded more than once, the last data written is used.
- R8: Write strobes that begin while `busy` is 1 are ignored. They load nothing, do not open a new load and do not change `pageErr`.
- R9: Pulsing `oeN` low between byte loads while `weN` is high neither ends nor extends the open load.
- R10: After reset, `busy`, `pageErr` and `arrWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Byte address (page in the upper bits, offset in the lower bits) |
| dataIn | input | DATA_W | Write data |
| arrWrEn | output | 1 | Array write enable, one byte per cycle |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | DATA_W | Array write data |
| busy | output | 1 | Programming phase in progress |
| pageErr | output | 1 | Sticky flag for a byte dropped on a page mismatch |

## Verification
The assertions check four things on every cycle:
- array writes occur only while `busy` is high, and the page they address holds steady throughout programming;
- `pageErr` never falls before reset;
- each `busy` pulse lasts exactly PROG_CYCLES cycles;
- programming never starts while a strobe is in progress.

Only the directed scenarios can show the cycle in which the timeout expires, which address and data edges are captured, the outcome of duplicate offsets, the dropping of foreign-page bytes, and the inertness of inhibited or busy-time strobes. The bench judges those by comparing a bench-side array model against its own expected image.

// File: rtl/plw_pkg.sv
package plw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;   // accepted strobe start: capture offset
    logic holdData;    // strobe active this cycle: track data bus
    logic commit;      // accepted strobe end: store byte in buffer
    logic progRun;     // programming phase active
    logic progInPage;  // programming index still inside the page
    logic clearAll;    // last programming cycle: empty the buffer
  } plwStrobe_t;
endpackage

// File: rtl/plw_ctrl.sv
module plw_ctrl
  import plw_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int OFF_W       = 7,
  parameter int LOAD_WINDOW = 10000,
  parameter int PROG_CYCLES = 300000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [ADDR_W-OFF_W-1:0] addrPage,
  output plwStrobe_t              ctl,
  output logic [OFF_W-1:0]        progIdx,
  output logic [ADDR_W-OFF_W-1:0] openPage,
  output logic                    busy,
  output logic                    pageErr
);
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int TMR_W      = $clog2(LOAD_WINDOW + 1);
  localparam int PRG_W      = $clog2(PROG_CYCLES + 1);

  plwState_e         state;
  logic              strobeQ;
  logic              acceptQ;
  logic [TMR_W-1:0]  tmr;
  logic [PRG_W-1:0]  prgCnt;
  logic [PAGE_W-1:0] pageQ;

  logic strobeNow, startEv, endEv, pageMatch;
  logic acceptStart, dropStart, timerDone, expire, progLast;

  always_comb begin
    strobeNow   = !ceN && !weN && oeN;
    startEv     = strobeNow && !strobeQ;
    endEv       = !strobeNow && strobeQ;
    pageMatch   = (addrPage == pageQ);
    acceptStart = startEv && ((state == ST_IDLE) || ((state == ST_LOAD) && pageMatch));
    dropStart   = startEv && (state == ST_LOAD) && !pageMatch;
    timerDone   = (tmr >= TMR_W'(LOAD_WINDOW - 1));
    expire      = (state == ST_LOAD) && timerDone && !strobeNow && !strobeQ;
    progLast    = (prgCnt == PRG_W'(PROG_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      strobeQ <= 1'b0;
      acceptQ <= 1'b0;
      tmr     <= '0;
      prgCnt  <= '0;
      pageQ   <= '0;
      pageErr <= 1'b0;
    end else begin
      strobeQ <= strobeNow;
      if (startEv)    acceptQ <= acceptStart;
      else if (endEv) acceptQ <= 1'b0;
      if (dropStart)  pageErr <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (acceptStart) begin
            state <= ST_LOAD;
            pageQ <= addrPage;
            tmr   <= '0;
          end
        end
        ST_LOAD: begin
          if (acceptStart) begin
            tmr <= '0;
          end else if (expire) begin
            state  <= ST_PROG;
            prgCnt <= '0;
          end else if (!timerDone) begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PROG: begin
          if (progLast) state <= ST_IDLE;
          else          prgCnt <= prgCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchAddr  = acceptStart;
    ctl.holdData   = strobeNow;
    ctl.commit     = endEv && acceptQ;
    ctl.progRun    = (state == ST_PROG);
    ctl.progInPage = (prgCnt < PRG_W'(PAGE_BYTES));
    ctl.clearAll   = (state == ST_PROG) && progLast;
    progIdx        = prgCnt[OFF_W-1:0];
    openPage       = pageQ;
    busy           = (state == ST_PROG);
  end
endmodule

// File: rtl/plw_datapath.sv
module plw_datapath
  import plw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  plwStrobe_t              ctl,
  input  logic [OFF_W-1:0]        progIdx,
  input  logic [OFF_W-1:0]        addrOff,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [ADDR_W-OFF_W-1:0] openPage,
  output logic                    arrWrEn,
  output logic [ADDR_W-1:0]       arrWrAddr,
  output logic [DATA_W-1:0]       arrWrData
);
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [OFF_W-1:0]      offQ;
  logic [DATA_W-1:0]     dataQ;
  logic [DATA_W-1:0]     bufQ [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ  <= '0;
      dataQ <= '0;
    end else begin
      if (ctl.latchAddr) offQ  <= addrOff;
      if (ctl.holdData)  dataQ <= dataIn;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gEntry
    logic hit;
    assign hit = ctl.commit && (offQ == OFF_W'(g));
    always_ff @(posedge clk) begin
      if (hit) bufQ[g] <= dataQ;
    end
    always_ff @(posedge clk) begin
      if (!rstN)             validQ[g] <= 1'b0;
      else if (ctl.clearAll) validQ[g] <= 1'b0;
      else if (hit)          validQ[g] <= 1'b1;
    end
  end

  always_comb begin
    arrWrEn   = ctl.progRun && ctl.progInPage && validQ[progIdx];
    arrWrAddr = {openPage, progIdx};
    arrWrData = bufQ[progIdx];
  end
endmodule

// File: rtl/page_load_writer.sv
module page_load_writer
  import plw_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int LOAD_WINDOW = 10000,
  parameter int PROG_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic              busy,
  output logic              pageErr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  plwStrobe_t        ctl;
  logic [OFF_W-1:0]  progIdx;
  logic [PAGE_W-1:0] openPage;

  plw_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrPage(addr[ADDR_W-1:OFF_W]),
    .ctl(ctl), .progIdx(progIdx), .openPage(openPage),
    .busy(busy), .pageErr(pageErr)
  );

  plw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .progIdx(progIdx),
    .addrOff(addr[OFF_W-1:0]), .dataIn(dataIn), .openPage(openPage),
    .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );
endmodule

// File: rtl/plw_checker.sv
module plw_checker #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 300000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic              busy,
  input logic              pageErr,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  int unsigned runLen;
  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  // R6: array writes only during the programming phase
  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  // R6: the page being written does not change while programming
  a_r6_page_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(arrWrAddr[ADDR_W-1:OFF_W]));

  // R6: each busy pulse has the programmed length
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == PROG_CYCLES));

  // R4: page error flag is sticky
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr);

  // R5: programming never begins in the middle of a write strobe
  a_r5_no_start_midstrobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ceN || weN || !oeN));
endmodule

bind page_load_writer plw_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
  .busy(busy), .pageErr(pageErr), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr)
);

// File: tb/tb_page_load_writer.sv
module tb_page_load_writer;
  localparam int W = 64;
  localparam int P = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        arrWrEn;
  logic [14:0] arrWrAddr;
  logic [7:0]  arrWrData;
  logic        busy, pageErr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mem    [512];
  logic [7:0] expMem [512];
  bit orderBad = 0, highBad = 0, seenRun = 0;
  logic [6:0] lastOff = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_load_writer #(.LOAD_WINDOW(W), .PROG_CYCLES(P)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData), .busy(busy), .pageErr(pageErr)
  );

  // bench-side array model
  always @(posedge clk) begin
    if (arrWrEn) begin
      mem[arrWrAddr[8:0]] <= arrWrData;
      if (arrWrAddr[14:9] != 0) highBad <= 1;
      if (seenRun && arrWrAddr[6:0] <= lastOff) orderBad <= 1;
      lastOff <= arrWrAddr[6:0];
      seenRun <= 1;
    end else if (!busy) begin
      seenRun <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input int page, input int off);
    return {8'(page), 7'(off)};
  endfunction

  task automatic writeByte(input logic [14:0] a, input logic [7:0] d, output int sc);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 0; weN = 0; oeN = 1;
    sc = cyc + 1;
    repeat (2) @(negedge clk);
    ceN = 1; weN = 1;
    @(negedge clk);
  endtask

  task automatic waitBusy(output int c);
    int n = 0;
    while (!busy && n < 5000) begin @(negedge clk); n++; end
    c = cyc;
  endtask

  task automatic measureBusy(output int width);
    width = 0;
    while (busy && width < 5000) begin width++; @(negedge clk); end
  endtask

  task automatic compareArray(input string req);
    int bad = -1;
    for (int i = 0; i < 512; i++) if (bad < 0 && mem[i] !== expMem[i]) bad = i;
    if (bad < 0) check(1, req, 0, 0);
    else check(0, {req, " array byte"}, int'(mem[bad]), int'(expMem[bad]));
  endtask

  task automatic quietWindow(input string req);
    int seen = 0;
    for (int i = 0; i < W + 20; i++) begin @(negedge clk); if (busy) seen++; end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic tReset();
    check(busy == 0, "R10 busy after reset", busy, 0);
    check(pageErr == 0, "R10 pageErr after reset", pageErr, 0);
    check(arrWrEn == 0, "R10 arrWrEn after reset", arrWrEn, 0);
  endtask

  task automatic tBasicPage();
    int s, c, w;
    writeByte(mk(2, 0), 8'h11, s);
    writeByte(mk(2, 5), 8'h22, s);
    writeByte(mk(2, 127), 8'h33, s);
    writeByte(mk(2, 5), 8'h44, s);
    expMem[256 + 0] = 8'h11; expMem[256 + 5] = 8'h44; expMem[256 + 127] = 8'h33;
    waitBusy(c);
    check(c == s + W, "R5 timeout start cycle", c - s, W);
    measureBusy(w);
    check(w == P, "R6 busy length", w, P);
    compareArray("R7 loaded offsets only, last data wins");
    check(pageErr == 0, "R4 no error on same page", pageErr, 0);
  endtask

  task automatic tCeControlled();
    int c, w;
    @(negedge clk); addr = mk(1, 20); weN = 0; dataIn = 8'h5C;
    @(negedge clk); addr = mk(1, 21); ceN = 0; dataIn = 8'hD1;
    @(negedge clk);
    @(negedge clk); ceN = 1; dataIn = 8'hD2; addr = mk(1, 22);
    @(negedge clk); weN = 1;
    expMem[128 + 21] = 8'hD1;
    waitBusy(c);
    measureBusy(w);
    compareArray("R2 R3 address at last fall, data before first rise");
  endtask

  task automatic tInhibit();
    @(negedge clk); addr = mk(0, 1); dataIn = 8'hEE; ceN = 0; weN = 0; oeN = 0;
    repeat (4) @(negedge clk);
    ceN = 1; oeN = 1;
    repeat (4) @(negedge clk);
    weN = 1; ceN = 0;
    repeat (3) @(negedge clk);
    ceN = 1;
    quietWindow("R1 inhibited strobes start nothing");
    compareArray("R1 array untouched by inhibited strobes");
  endtask

  task automatic tLongLoad();
    int s, c, w, early = 0;
    for (int k = 0; k < 20; k++) begin
      writeByte(mk(3, 6 * k), 8'(k + 100), s);
      expMem[384 + 6 * k] = 8'(k + 100);
      oeN = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (busy) early++; end
      oeN = 1;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) early++; end
    end
    check(early == 0, "R9 load kept open across read pulses", early, 0);
    waitBusy(c);
    check(c == s + W, "R5 long load ends one window after last byte", c - s, W);
    measureBusy(w);
    compareArray("R5 R9 all bytes of long load committed");
  endtask

  task automatic tBusyIgnore();
    int s, c, w;
    writeByte(mk(0, 10), 8'h7A, s);
    expMem[10] = 8'h7A;
    waitBusy(c);
    writeByte(mk(0, 11), 8'h01, s);
    writeByte(mk(1, 0), 8'h02, s);
    check(busy == 1, "R8 strobes issued while busy", busy, 1);
    measureBusy(w);
    quietWindow("R8 busy-time strobes open no load");
    compareArray("R8 busy-time strobes write nothing");
    check(pageErr == 0, "R8 pageErr unchanged", pageErr, 0);
  endtask

  task automatic tPageErr();
    int s1, s2, c, w;
    writeByte(mk(1, 40), 8'h9B, s1);
    repeat (10) @(negedge clk);
    writeByte(mk(2, 40), 8'h9C, s2);
    expMem[128 + 40] = 8'h9B;
    check(pageErr == 1, "R4 foreign page sets pageErr", pageErr, 1);
    waitBusy(c);
    check(c == s1 + W, "R4 dropped byte does not restart timeout", c - s1, W);
    measureBusy(w);
    compareArray("R4 dropped byte not written");
    check(pageErr == 1, "R4 pageErr sticky", pageErr, 1);
    doReset();
    check(pageErr == 0, "R10 reset clears pageErr", pageErr, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      expMem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tBasicPage();
    tCeControlled();
    tInhibit();
    tLongLoad();
    tBusyIgnore();
    tPageErr();
    check(orderBad == 0, "R6 ascending offset order", orderBad, 0);
    check(highBad == 0, "R6 array writes keep load page", highBad, 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end
endmodule